// File: doc/BRIEF.md
# Banded Rolling-Shutter Row Sequencer

This block produces the row timing for a pixel array split into a north half and a south half. Each half is cut into horizontal bands, and each band holds `ROWS` pixel rows. The shutter rolls band by band. Inside a band, exposure is time-coherent: one reset pulse reaches every row of the band at once and starts integration. One transfer pulse reaches every row at once and ends it.

After the transfer, the rows of the band are converted one at a time. The same row index is selected in both halves, so the north and south column converters work in parallel. Each row gets `RAMP_CYC` cycles of ramp, followed by a single copy strobe that moves the converted codes into the output registers. The next row is selected only after that strobe. When the last row of the last band has been copied, the sequencer goes idle and waits for the next frame start.

The integration length is given in clock cycles and is sampled when a frame starts. A requested length shorter than one band's readout time (`ROWS*(RAMP_CYC+1)` cycles) is raised to that readout time.

Top module: `band_row_sequencer`

## Requirements
- R1: One cycle after a frame start is accepted in idle, `row_rst` is all ones for exactly one cycle. Every other row line is low in that cycle. The same happens at the start of each band.
- R2: `row_xfer` is all ones for exactly one cycle and ends the band's integration. Integration is measured as the cycles strictly between the reset cycle and the transfer cycle.
- R3: The integration length equals `int_len` as sampled at frame start. If `int_len` is below `ROWS*(RAMP_CYC+1)`, that readout time is used instead. The sampled value holds for the whole frame.
- R4: After the transfer, rows 0 to `ROWS-1` are selected in increasing order. Bit r of the select vector is the only bit set while row r is handled, and `row_idx` equals r. At all other times `row_idx` is 0.
- R5: `sel_south` equals `sel_north` at every cycle, so both halves convert the same row together.
- R6: Each selected row sees `ramp_run` high for `RAMP_CYC` cycles and then `copy_stb` high for one cycle, with the same row still selected. The next selection starts in the following cycle.
- R7: `band_addr` counts from 0 to `BANDS-1`, one band after another. Each band lasts `L+2+ROWS*(RAMP_CYC+1)` cycles, where L is the integration length from R3.
- R8: A frame start, or a change of `int_len`, while a frame is in progress has no effect on any output.
- R9: After reset, and after the last copy of a frame, every output is 0 until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame when the sequencer is idle |
| int_len | input | LEN_W | Requested integration length in cycles |
| band_addr | output | clog2(BANDS) | Band being exposed or read |
| row_idx | output | clog2(ROWS) | Row within the band being read |
| row_rst | output | ROWS | Reset lines of the band's rows |
| row_xfer | output | ROWS | Transfer lines of the band's rows |
| sel_north | output | ROWS | One-hot row select, north half |
| sel_south | output | ROWS | One-hot row select, south half |
| ramp_run | output | 1 | Converter ramp active |
| copy_stb | output | 1 | Copy converted codes to output registers |

## Verification
The assertions rely on `int_len` fitting in `LEN_W` bits. They also rely on `RAMP_CYC` and one band's readout time both fitting the counter width. Beyond that they make no assumption about when `frame_start` arrives; it may be pulsed at any time. The stimulus uses a small configuration and sweeps integration lengths below, at, one above and well above the readout floor. One frame injects a stray start pulse and changes `int_len` partway through. Every cycle of every frame is compared with a position computed arithmetically from the cycle count.

// File: rtl/band_row_sequencer.sv
module band_row_sequencer #(
  parameter int ROWS     = 20,
  parameter int BANDS    = 42,
  parameter int RAMP_CYC = 512,
  parameter int LEN_W    = 20,
  localparam int ROW_W   = (ROWS  > 1) ? $clog2(ROWS)  : 1,
  localparam int BAND_W  = (BANDS > 1) ? $clog2(BANDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [LEN_W-1:0]  int_len,
  output logic [BAND_W-1:0] band_addr,
  output logic [ROW_W-1:0]  row_idx,
  output logic [ROWS-1:0]   row_rst,
  output logic [ROWS-1:0]   row_xfer,
  output logic [ROWS-1:0]   sel_north,
  output logic [ROWS-1:0]   sel_south,
  output logic              ramp_run,
  output logic              copy_stb
);
  localparam logic [LEN_W-1:0]  TREAD    = LEN_W'(ROWS * (RAMP_CYC + 1));
  localparam logic [LEN_W-1:0]  RAMP_END = LEN_W'(RAMP_CYC - 1);
  localparam logic [ROW_W-1:0]  ROW_END  = ROW_W'(ROWS - 1);
  localparam logic [BAND_W-1:0] BAND_END = BAND_W'(BANDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_INTG, S_XFER, S_CONV, S_COPY} st_t;

  st_t               st;
  logic [BAND_W-1:0] band_q;
  logic [ROW_W-1:0]  row_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              reading;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      band_q <= '0;
      row_q  <= '0;
      cnt_q  <= '0;
      len_q  <= TREAD;
    end else begin
      case (st)
        S_IDLE: if (frame_start) begin
          st     <= S_RST;
          band_q <= '0;
          row_q  <= '0;
          len_q  <= (int_len < TREAD) ? TREAD : int_len;
        end
        S_RST: begin
          st    <= S_INTG;
          cnt_q <= '0;
        end
        S_INTG: begin
          if (cnt_q == len_q - 1'b1) st <= S_XFER;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_XFER: begin
          st    <= S_CONV;
          row_q <= '0;
          cnt_q <= '0;
        end
        S_CONV: begin
          if (cnt_q == RAMP_END) st <= S_COPY;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_COPY: begin
          cnt_q <= '0;
          if (row_q == ROW_END) begin
            row_q <= '0;
            if (band_q == BAND_END) begin
              st     <= S_IDLE;
              band_q <= '0;
            end else begin
              st     <= S_RST;
              band_q <= band_q + 1'b1;
            end
          end else begin
            row_q <= row_q + 1'b1;
            st    <= S_CONV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign reading   = (st == S_CONV) || (st == S_COPY);
  assign band_addr = band_q;
  assign row_idx   = row_q;
  assign row_rst   = {ROWS{st == S_RST}};
  assign row_xfer  = {ROWS{st == S_XFER}};
  assign sel_north = reading ? (ROWS'(1) << row_q) : '0;
  assign sel_south = sel_north;
  assign ramp_run  = (st == S_CONV);
  assign copy_stb  = (st == S_COPY);
endmodule

// File: rtl/band_row_sequencer_chk.sv
module band_row_sequencer_chk #(
  parameter int ROWS     = 20,
  parameter int RAMP_CYC = 512,
  parameter int ROW_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [ROW_W-1:0] row_idx,
  input logic [ROWS-1:0]  row_rst,
  input logic [ROWS-1:0]  row_xfer,
  input logic [ROWS-1:0]  sel_north,
  input logic             ramp_run,
  input logic             copy_stb
);
  localparam int unsigned TREAD = ROWS * (RAMP_CYC + 1);
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= 0;
    else if (|row_rst) gap <= 0;
    else if (gap < TREAD + 2) gap <= gap + 1;
  end

  assert_reset_alone_R1: assert property (@(posedge clk) disable iff (rst)
    (|row_rst) |-> ((&row_rst) && row_xfer == '0 && sel_north == '0 && !ramp_run));

  assert_integ_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (|row_xfer) |-> (gap >= TREAD));

  assert_one_row_R4: assert property (@(posedge clk) disable iff (rst)
    (ramp_run || copy_stb) |-> ($countones(sel_north) == 1));

  assert_row_range_R4: assert property (@(posedge clk) disable iff (rst)
    int'(row_idx) < ROWS);

  assert_copy_after_ramp_R6: assert property (@(posedge clk) disable iff (rst)
    copy_stb |-> ($past(ramp_run) && !ramp_run));

  assert_sel_moves_R6: assert property (@(posedge clk) disable iff (rst)
    copy_stb |=> (sel_north != $past(sel_north)));
endmodule

bind band_row_sequencer band_row_sequencer_chk #(
  .ROWS(ROWS), .RAMP_CYC(RAMP_CYC), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .row_idx(row_idx), .row_rst(row_rst),
  .row_xfer(row_xfer), .sel_north(sel_north), .ramp_run(ramp_run),
  .copy_stb(copy_stb)
);

// File: tb/band_row_sequencer_tb.sv
`timescale 1ns/1ps
module band_row_sequencer_tb;
  localparam int ROWS = 4, BANDS = 3, RAMP = 3, LEN_W = 8;
  localparam int TREAD = ROWS * (RAMP + 1);

  logic clk = 0, rst = 1, frame_start = 0;
  logic [LEN_W-1:0] int_len = '0;
  logic [1:0] band_addr;
  logic [1:0] row_idx;
  logic [ROWS-1:0] row_rst, row_xfer, sel_north, sel_south;
  logic ramp_run, copy_stb;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  band_row_sequencer #(.ROWS(ROWS), .BANDS(BANDS), .RAMP_CYC(RAMP), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .int_len(int_len),
    .band_addr(band_addr), .row_idx(row_idx), .row_rst(row_rst), .row_xfer(row_xfer),
    .sel_north(sel_north), .sel_south(sel_south), .ramp_run(ramp_run), .copy_stb(copy_stb));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, int'({band_addr, row_idx, row_rst, row_xfer, sel_north, sel_south, ramp_run, copy_stb}), 0);
  endtask

  task automatic run_frame(input int len, input bit disturb);
    int L, P, total;
    L = (len < TREAD) ? TREAD : len;
    P = L + 2 + TREAD;
    total = P * BANDS;
    int_len = LEN_W'(len);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    for (int t = 0; t < total; t++) begin
      int b, o, r, p, erd;
      b = t / P;
      o = t % P;
      erd = (o >= L + 2) ? 1 : 0;
      r = erd ? (o - L - 2) / (RAMP + 1) : 0;
      p = erd ? (o - L - 2) % (RAMP + 1) : 0;
      chk("R7 band", int'(band_addr), b);
      chk("R1 reset", int'(row_rst), (o == 0) ? (1 << ROWS) - 1 : 0);
      chk(disturb ? "R8 xfer" : "R2 R3 xfer", int'(row_xfer), (o == L + 1) ? (1 << ROWS) - 1 : 0);
      chk("R4 select", int'(sel_north), erd ? (1 << r) : 0);
      chk("R4 row_idx", int'(row_idx), r);
      chk("R5 south", int'(sel_south), int'(sel_north));
      chk("R6 ramp", int'(ramp_run), (erd && p < RAMP) ? 1 : 0);
      chk("R6 copy", int'(copy_stb), (erd && p == RAMP) ? 1 : 0);
      if (disturb && t == 7) begin frame_start = 1; int_len = 8'd200; end
      if (disturb && t == 8) frame_start = 0;
      if (disturb && t == P + 3) frame_start = 1;
      if (disturb && t == P + 4) frame_start = 0;
      @(negedge clk);
    end
    for (int k = 0; k < 3; k++) begin
      chk_idle("R9 after frame");
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R9 reset state");
    rst = 0;
    @(negedge clk);
    chk_idle("R9 idle no start");
    run_frame(20, 0);
    run_frame(5, 0);
    run_frame(TREAD, 0);
    run_frame(TREAD + 1, 0);
    run_frame(0, 0);
    run_frame(30, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule